// File: doc/BRIEF.md
# ModR/M effective address generator

This unit turns an addressing-mode byte and the displacement bytes that follow it into a 32-bit memory effective address. A one-cycle `start` strobe presents the mode byte. The unit reads the base register through a combinational read port into an eight-entry register file. Indices 0 to 7 name EAX, ECX, EDX, EBX, ESP, EBP, ESI and EDI. The unit then pulls any displacement bytes it needs, one per cycle, over a valid/ready byte stream. When it has the result it raises `done` for one cycle, together with the address, the middle (reg/subop) field, a memory/direct flag, an unsupported-encoding flag and the number of displacement bytes it took.

The mode byte is split into three fields. Bits 7:6 give the mode, bits 5:3 the reg/subop field and bits 2:0 the rm register index. This unit supports a subset of the usual encodings. In mode 00 the address is the register's value, except for rm=101, which takes an absolute 32-bit address from the stream. Mode 01 adds a sign-extended byte and mode 10 adds a 32-bit value, and in both of them the displacement is fetched and added only when the base register is nonzero. Register-direct mode 11 is passed through with the memory flag low. The scaled-index encoding (rm=100 outside mode 11) is reported as unsupported.

Top module: `modrm_ea`

## Requirements
- R1: After reset, `done`, `byte_ready`, `is_mem`, `unsupported` and `disp_count` are all zero.
- R2: `reg_field` reports bits 5:3 of the mode byte accepted with the last `start`.
- R3: Mode 00 with rm other than 100 and 101 yields the value of register rm, consumes no bytes and raises `done` in the cycle after `start`.
- R4: Mode 00 with rm=101 ignores the register file and takes four bytes as the absolute address, assembled little-endian (first byte in bits 7:0).
- R5: Mode 01 with a nonzero base adds one byte, sign-extended to 32 bits, to register rm (base 0x2001 plus 0xff gives 0x2000).
- R6: Mode 10 with a nonzero base adds a four-byte little-endian displacement to register rm, with wraparound (0xffffffff acts as minus one).
- R7: In modes 01 and 10, a zero base yields address 0 with no byte consumed and `done` in the cycle after `start`.
- R8: Mode 11 drives `is_mem` low, returns register rm's value as `addr` and consumes no bytes. Every other mode drives `is_mem` high.
- R9: rm=100 with a mode other than 11 raises `unsupported`, consumes no bytes and yields address 0.
- R10: `byte_ready` is high only while displacement bytes are still owed. `done` rises in the cycle after the last byte is accepted. Bytes offered at any other time are ignored, and `disp_count` equals the number of bytes accepted since the last `start`.
- R11: `addr` holds between results. A `start` that arrives while bytes are still owed is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Strobe presenting a new mode byte |
| modrm | input | 8 | Addressing-mode byte, sampled with `start` |
| rf_idx | output | 3 | Register file read index |
| rf_data | input | 32 | Register file read data for `rf_idx` |
| byte_valid | input | 1 | Displacement byte available |
| byte_data | input | 8 | Displacement byte |
| byte_ready | output | 1 | Unit is waiting for a displacement byte |
| done | output | 1 | One-cycle result pulse |
| addr | output | 32 | Effective address (register value in mode 11) |
| reg_field | output | 3 | Bits 5:3 of the mode byte |
| is_mem | output | 1 | High when the result is a memory address |
| unsupported | output | 1 | Scaled-index encoding seen |
| disp_count | output | 3 | Displacement bytes consumed for the current result |

## Verification
A wrong byte count would show in the same cycle as a stuck or early `byte_ready`. If `done` came too early, the address would be built from a partial displacement. If it came too late, the bench would see an extra accepted byte on `disp_count`. Either shows up within one cycle of the last byte. A bad byte placement or sign extension corrupts `addr` at the `done` pulse. A missed zero-base test shows as displacement bytes taken where none are owed. Extra bytes offered after `done` and a second `start` sent during collection both probe whether state leaks into the held result.

// File: rtl/modrm_ea.sv
module modrm_ea #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    modrm,
  output logic [2:0]    rf_idx,
  input  logic [AW-1:0] rf_data,
  input  logic          byte_valid,
  input  logic [7:0]    byte_data,
  output logic          byte_ready,
  output logic          done,
  output logic [AW-1:0] addr,
  output logic [2:0]    reg_field,
  output logic          is_mem,
  output logic          unsupported,
  output logic [$clog2(AW/8+1)-1:0] disp_count
);
  localparam int NB = AW / 8;
  localparam int CW = $clog2(NB + 1);

  logic          busy, done_q, mem_q, unsup_q, abs_q;
  logic [CW-1:0] need_q, cnt_q, need_d;
  logic [AW-1:0] base_q, acc_q, addr_q;
  logic [2:0]    rm_q, reg_q;

  wire [1:0] md        = modrm[7:6];
  wire [2:0] rm        = modrm[2:0];
  wire       go        = start && !busy;
  wire       take      = busy && byte_valid;
  wire       direct    = (md == 2'b11);
  wire       sib       = !direct && (rm == 3'b100);
  wire       absolute  = (md == 2'b00) && (rm == 3'b101);
  wire       base_nz   = |rf_data;

  always_comb begin
    need_d = '0;
    if (direct || sib)      need_d = '0;
    else if (absolute)      need_d = CW'(NB);
    else if (md == 2'b01)   need_d = base_nz ? CW'(1) : '0;
    else if (md == 2'b10)   need_d = base_nz ? CW'(NB) : '0;
  end

  wire [AW-1:0] acc_nx = acc_q | (AW'(byte_data) << (8 * cnt_q));
  wire [AW-1:0] disp   = (need_q == CW'(1)) ? {{(AW-8){acc_nx[7]}}, acc_nx[7:0]} : acc_nx;
  wire [AW-1:0] ea     = abs_q ? disp : base_q + disp;
  wire          last   = take && (cnt_q + CW'(1) == need_q);

  assign rf_idx      = start ? rm : rm_q;
  assign byte_ready  = busy;
  assign done        = done_q;
  assign addr        = addr_q;
  assign reg_field   = reg_q;
  assign is_mem      = mem_q;
  assign unsupported = unsup_q;
  assign disp_count  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done_q  <= 1'b0;
      mem_q   <= 1'b0;
      unsup_q <= 1'b0;
      abs_q   <= 1'b0;
      need_q  <= '0;
      cnt_q   <= '0;
      base_q  <= '0;
      acc_q   <= '0;
      addr_q  <= '0;
      rm_q    <= '0;
      reg_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        reg_q   <= modrm[5:3];
        rm_q    <= rm;
        base_q  <= rf_data;
        acc_q   <= '0;
        cnt_q   <= '0;
        need_q  <= need_d;
        abs_q   <= absolute;
        mem_q   <= !direct;
        unsup_q <= sib;
        if (need_d == '0) begin
          done_q <= 1'b1;
          addr_q <= sib ? '0 : rf_data;
        end else begin
          busy <= 1'b1;
        end
      end else if (take) begin
        acc_q <= acc_nx;
        cnt_q <= cnt_q + CW'(1);
        if (last) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
          addr_q <= ea;
        end
      end
    end
  end

  AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !byte_ready); // R10
  AST_BYTE_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && byte_ready) |=> (disp_count == $past(disp_count) + CW'(1))); // R10
  AST_DIRECT_NO_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    !is_mem |-> (disp_count == '0)); // R8
  AST_UNSUP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    unsupported |-> (addr == '0 && disp_count == '0)); // R9
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !byte_ready) |=> $stable(addr)); // R11
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    disp_count <= CW'(NB)); // R10
endmodule

// File: tb/modrm_ea_tb.sv
module modrm_ea_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 0, rst_n = 0, start = 0, byte_valid = 0;
  logic [7:0]  modrm = 0, byte_data = 0;
  logic [2:0]  rf_idx, reg_field;
  logic [31:0] rf_data, addr;
  logic        byte_ready, done, is_mem, unsupported;
  logic [2:0]  disp_count;
  logic [31:0] regs [8];
  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rf_data = regs[rf_idx];

  modrm_ea u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .modrm(modrm), .rf_idx(rf_idx),
    .rf_data(rf_data), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_ready(byte_ready), .done(done), .addr(addr), .reg_field(reg_field),
    .is_mem(is_mem), .unsupported(unsupported), .disp_count(disp_count));

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [7:0] m, input logic [31:0] d,
                                output logic [31:0] ea, output int n,
                                output bit mem, output bit uns);
    logic [31:0] b = regs[m[2:0]];
    mem = (m[7:6] != 2'b11);
    uns = mem && (m[2:0] == 3'b100);
    n = 0; ea = b;
    if (uns) ea = 0;
    else if (m[7:6] == 2'b00 && m[2:0] == 3'b101) begin n = 4; ea = d; end
    else if (m[7:6] == 2'b01 && b != 0) begin n = 1; ea = b + {{24{d[7]}}, d[7:0]}; end
    else if (m[7:6] == 2'b10 && b != 0) begin n = 4; ea = b + d; end
  endfunction

  function automatic string tag(input logic [7:0] m);
    if (m[7:6] == 2'b11) return "R8";
    if (m[2:0] == 3'b100) return "R9";
    if (m[7:6] == 2'b00) return (m[2:0] == 3'b101) ? "R4" : "R3";
    if (regs[m[2:0]] == 0) return "R7";
    return (m[7:6] == 2'b01) ? "R5" : "R6";
  endfunction

  task automatic run(input logic [7:0] m, input logic [31:0] d, input bit gaps);
    logic [31:0] ea; int n; bit mem, uns; int taken = 0, guard = 0; bit acc;
    string t = tag(m);
    model(m, d, ea, n, mem, uns);
    @(negedge clk); modrm = m; start = 1;
    @(negedge clk); start = 0;
    while (!done && guard < 60) begin
      byte_valid = gaps ? 1'($urandom % 2) : 1'b1;
      byte_data  = (taken < 4) ? d[8*taken +: 8] : 8'h00;
      acc = byte_valid && byte_ready;
      @(negedge clk);
      if (acc) taken++;
      guard++;
    end
    byte_valid = 0;
    chk({t, " done seen (R10)"}, 32'(done), 1);
    chk({t, " address"}, addr, ea);
    chk({t, " bytes taken (R10)"}, taken, n);
    chk({t, " disp_count (R10)"}, 32'(disp_count), n);
    chk({t, " is_mem (R8)"}, 32'(is_mem), 32'(mem));
    chk({t, " unsupported (R9)"}, 32'(unsupported), 32'(uns));
    chk("R2 reg_field", 32'(reg_field), 32'(m[5:3]));
    chk("R10 ready low at done", 32'(byte_ready), 0);
  endtask

  initial begin
    logic [31:0] hold_a; logic [2:0] hold_c;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 8; i++) regs[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 done", 32'(done), 0);
    chk("R1 byte_ready", 32'(byte_ready), 0);
    chk("R1 disp_count", 32'(disp_count), 0);
    chk("R1 is_mem", 32'(is_mem), 0);
    chk("R1 unsupported", 32'(unsupported), 0);
    rst_n = 1;

    regs[0] = 32'h2000; regs[3] = 32'h10;
    run(8'h18, 0, 0);                 // R3 mode 00 EAX
    run(8'h1d, 32'h0000_2000, 0);     // R4 absolute
    regs[0] = 32'h1ffe;
    run(8'h58, 32'h02, 0);            // R5 +2
    regs[0] = 32'h2001;
    run(8'h58, 32'hff, 1);            // R5 -1
    run(8'h98, 32'hffff_ffff, 1);     // R6 -1
    regs[1] = 0;
    run(8'h41, 32'h55, 0);            // R7 zero base mode 01
    run(8'h81, 32'h1234_5678, 0);     // R7 zero base mode 10
    run(8'hd8, 0, 0);                 // R8 direct
    run(8'h04, 0, 0);                 // R9
    run(8'h84, 0, 0);                 // R9

    // R10: bytes offered after done are ignored
    hold_a = addr; hold_c = disp_count;
    @(negedge clk); byte_valid = 1; byte_data = 8'hee;
    repeat (3) @(negedge clk);
    chk("R10 ready stays low when idle", 32'(byte_ready), 0);
    byte_valid = 0;
    chk("R10 count unchanged by idle bytes", 32'(disp_count), 32'(hold_c));
    chk("R11 addr held while idle", addr, hold_a);

    // R11: start during collection is ignored
    regs[2] = 32'h100;
    @(negedge clk); modrm = 8'h92; start = 1;
    @(negedge clk); start = 0; byte_valid = 1; byte_data = 8'h01;
    @(negedge clk); modrm = 8'hd8; start = 1; byte_valid = 0;
    @(negedge clk); start = 0; byte_valid = 1; byte_data = 8'h00;
    repeat (3) @(negedge clk);
    byte_valid = 0;
    chk("R11 result of first start", addr, 32'h101);
    chk("R11 reg_field of first start", 32'(reg_field), 3'd2);
    chk("R11 is_mem of first start", 32'(is_mem), 1);

    for (int k = 0; k < 300; k++) begin
      for (int i = 0; i < 8; i++) regs[i] = ($urandom % 4 == 0) ? 0 : $urandom;
      run(8'($urandom), $urandom, 1'($urandom % 2));
    end
    finish_run();
  end
endmodule